// File: doc/BRIEF.md
# Packed Shift-and-Insert Unit

This block merges bits of two 64-bit packed vectors. Each lane of a source vector is shifted left or right by a fixed amount. The bits the shift vacates are not zero-filled. They take the old contents of the same lane of the current destination vector. A single call can therefore place a bit field into each lane of a register while the surrounding bits stay as they were.

The caller supplies five things:
- the source vector;
- the present destination vector;
- a 4-bit opcode that selects the direction;
- a 6-bit immediate field and a high flag, which together form a 7-bit immediate;
- a valid strobe.

The lane width (8, 16, 32 or 64 bits) and the shift amount are both decoded from that one immediate. The new destination value appears one clock later, together with an output strobe. An immediate or opcode that cannot be decoded raises an illegal flag and returns the destination unchanged.

Top module: `vec_shift_insert`

## Requirements
- R1: The immediate is `imm = imm_top*64 + imm_field`. The lane width is the largest power of two not above `imm`: 8 for 8..15, 16 for 16..31, 32 for 32..63, 64 for 64..127. Lane i occupies bits [i*w +: w] of the vector.
- R2: Opcode 4'h5 (left insert) uses shift `s = imm - w`. Each lane result is `(src_lane << s)` truncated to w bits, ORed with the low `s` bits of the destination lane.
- R3: Opcode 4'h4 (right insert) uses shift `s = 2*w - imm`. Each lane result is `src_lane >> s` (logical), ORed with the high `s` bits of the destination lane.
- R4: Any opcode other than 4'h5 or 4'h4 raises `illegal` and returns `dst_vec` unchanged.
- R5: Lanes are independent. No shifted bit and no kept destination bit crosses a lane boundary.
- R6: A right insert with `imm` equal to a power of two (shift of w) returns the destination unchanged. A left insert with such an `imm` (shift 0) returns the source unchanged.
- R7: An immediate below 8 raises `illegal` and returns `dst_vec` unchanged.
- R8: `out_valid` is `in_valid` delayed by one clock, and `result` and `illegal` change only on a cycle that follows an accepted input.
- R9: While `rst_n` is low, `out_valid`, `illegal` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| op_code | input | 4 | Direction: 4'h5 left insert, 4'h4 right insert |
| imm_field | input | 6 | Low six bits of the immediate |
| imm_top | input | 1 | Adds 64 to the immediate |
| src_vec | input | 64 | Vector whose lanes are shifted |
| dst_vec | input | 64 | Current destination, source of kept bits |
| out_valid | output | 1 | Result valid |
| result | output | 64 | New destination vector |
| illegal | output | 1 | Immediate or opcode could not be decoded |

## Verification
A wrong width decode shows up in the first result as lanes misaligned at 8-, 16- or 32-bit boundaries. A wrong keep-mask shows up in the first result as destination bits lost, or source bits appearing where kept bits belong. The scoreboard compares each result in the cycle after its strobe, so any such fault is seen at the first affected operation. Inputs with all-ones sources over patterned destinations make a bit leaking across a lane boundary visible at once. The result register must hold between strobes, so a faulty register enable is caught on the first idle cycle.

// File: rtl/vec_shift_insert.sv
module vec_shift_insert #(
  parameter int DATA_W = 64,
  parameter logic [3:0] OP_LEFT = 4'h5,
  parameter logic [3:0] OP_RIGHT = 4'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op_code,
  input  logic [5:0]        imm_field,
  input  logic              imm_top,
  input  logic [DATA_W-1:0] src_vec,
  input  logic [DATA_W-1:0] dst_vec,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  localparam int NWID = 4;
  localparam int MIN_W = 8;

  logic [6:0] imm;
  logic [1:0] wsel;
  logic [7:0] lw;
  logic [7:0] sh_l, sh_r;
  logic       is_left, is_right, bad;
  logic [DATA_W-1:0] by_width [NWID];
  logic [DATA_W-1:0] next_res;

  assign imm      = {imm_top, imm_field};
  assign wsel     = imm[6] ? 2'd3 : imm[5] ? 2'd2 : imm[4] ? 2'd1 : 2'd0;
  assign lw       = 8'(MIN_W) << wsel;
  assign sh_l     = {1'b0, imm} - lw;
  assign sh_r     = (lw << 1) - {1'b0, imm};
  assign is_left  = (op_code == OP_LEFT);
  assign is_right = (op_code == OP_RIGHT);
  assign bad      = (imm < 7'(MIN_W)) || !(is_left || is_right);

  for (genvar k = 0; k < NWID; k++) begin : g_wid
    localparam int LW = MIN_W << k;
    localparam int NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [LW-1:0] s, d, keep_l, keep_r;
      assign s      = src_vec[l*LW +: LW];
      assign d      = dst_vec[l*LW +: LW];
      assign keep_l = ~({LW{1'b1}} << sh_l);
      assign keep_r = ~({LW{1'b1}} >> sh_r);
      assign by_width[k][l*LW +: LW] = is_left ? ((s << sh_l) | (d & keep_l))
                                               : ((s >> sh_r) | (d & keep_r));
    end
  end

  assign next_res = bad ? dst_vec : by_width[wsel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= next_res;
        illegal <= bad;
      end
    end
  end
endmodule

// File: rtl/vec_shift_insert_chk.sv
module vec_shift_insert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  op_code,
  input logic [5:0]  imm_field,
  input logic        imm_top,
  input logic [63:0] src_vec,
  input logic [63:0] dst_vec,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        illegal
);
  logic [6:0] imm;
  logic       pow2;
  assign imm  = {imm_top, imm_field};
  assign pow2 = ($countones(imm) == 1) && (imm >= 7'd8);

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(illegal)));
  a_r7_small_imm: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && imm < 7'd8) |=> (illegal && result == $past(dst_vec)));
  a_r4_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code != 4'h5 && op_code != 4'h4) |=> (illegal && result == $past(dst_vec)));
  a_r6_right_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 4'h4 && pow2) |=> (!illegal && result == $past(dst_vec)));
  a_r6_left_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 4'h5 && pow2) |=> (!illegal && result == $past(src_vec)));
  a_r8_illegal_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> $past(in_valid));
endmodule

bind vec_shift_insert vec_shift_insert_chk chk_i (.*);

// File: tb/vec_shift_insert_tb_top.sv
module vec_shift_insert_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_code = 4'h0;
  logic [5:0]  imm_field = '0;
  logic        imm_top = 1'b0;
  logic [63:0] src_vec = '0;
  logic [63:0] dst_vec = '0;
  logic        out_valid, illegal;
  logic [63:0] result;

  typedef struct {
    logic [63:0] res;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [63:0] last_res = '0;
  logic        last_ill = 1'b0;
  logic        have_last = 1'b0;

  always #5 clk = ~clk;

  vec_shift_insert dut_i (.*);

  function automatic exp_t model(logic [63:0] s, logic [63:0] d, logic [3:0] op, int imm, string tag);
    exp_t e;
    int w, sh;
    logic [63:0] lm, sl, dl, r;
    e.tag = tag;
    e.ill = 1'b0;
    e.res = d;
    if (imm < 8 || (op != 4'h5 && op != 4'h4)) begin
      e.ill = 1'b1;
      return e;
    end
    w  = imm >= 64 ? 64 : imm >= 32 ? 32 : imm >= 16 ? 16 : 8;
    lm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    e.res = '0;
    for (int l = 0; l < 64 / w; l++) begin
      sl = (s >> (l * w)) & lm;
      dl = (d >> (l * w)) & lm;
      if (op == 4'h5) begin
        sh = imm - w;
        r = ((sl << sh) & lm) | (dl & ((64'd1 << sh) - 64'd1));
      end else begin
        sh = 2 * w - imm;
        r = (sl >> sh) | (dl & ~(lm >> sh) & lm);
      end
      e.res = e.res | (r << (l * w));
    end
    return e;
  endfunction

  task automatic send(logic [63:0] s, logic [63:0] d, logic [3:0] op, int imm, string tag);
    @(negedge clk);
    src_vec   = s;
    dst_vec   = d;
    op_code   = op;
    imm_top   = imm[6];
    imm_field = imm[5:0];
    in_valid  = 1'b1;
    sb.push_back(model(s, d, op, imm, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check(logic cond, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8 unexpected out_valid", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(result == e.res, e.tag, result, e.res);
          check(illegal == e.ill, {e.tag, " illegal"}, 64'(illegal), 64'(e.ill));
        end
        last_res  = result;
        last_ill  = illegal;
        have_last = 1'b1;
      end else if (have_last) begin
        check(result == last_res && illegal == last_ill, "R8 hold", result, last_res);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && illegal == 1'b0, "R9 reset flags", 64'({out_valid, illegal}), 64'd0);
    check(result == 64'd0, "R9 reset result", result, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    send(64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 4'h5, 11, "R2 left w8 s3");
    send(64'h0123_4567_89AB_CDEF, 64'hA5A5_A5A5_A5A5_A5A5, 4'h5, 21, "R2 left w16 s5");
    send(64'hDEAD_BEEF_CAFE_F00D, 64'h1111_2222_3333_4444, 4'h5, 44, "R2 left w32 s12");
    send(64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 4'h5, 127, "R2 left w64 s63");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 4'h4, 13, "R3 right w8 s3");
    send(64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 4'h4, 17, "R3 right w16 s15");
    send(64'hDEAD_BEEF_CAFE_F00D, 64'hFFFF_FFFF_0000_0000, 4'h4, 40, "R3 right w32 s24");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555, 4'h4, 65, "R3 right w64 s63");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 4'h5, 15, "R5 left no leak w8");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 4'h4, 9, "R5 right no leak w8");
    send(64'h8181_8181_8181_8181, 64'h0000_0000_0000_0000, 4'h4, 31, "R5 right no leak w16");
    for (int w = 8; w <= 64; w = w * 2) begin
      send(64'hCAFE_BABE_1234_5678, 64'h0F0F_0F0F_0F0F_0F0F, 4'h4, w, "R6 right full width");
      send(64'hCAFE_BABE_1234_5678, 64'h0F0F_0F0F_0F0F_0F0F, 4'h5, w, "R6 left zero shift");
    end
    send(64'h1234_5678_9ABC_DEF0, 64'hFEED_FACE_0BAD_F00D, 4'h5, 7, "R7 imm 7");
    send(64'h1234_5678_9ABC_DEF0, 64'hFEED_FACE_0BAD_F00D, 4'h4, 0, "R7 imm 0");
    send(64'h1234_5678_9ABC_DEF0, 64'hFEED_FACE_0BAD_F00D, 4'h3, 20, "R4 bad opcode");
    send(64'h1234_5678_9ABC_DEF0, 64'hFEED_FACE_0BAD_F00D, 4'h5, 20, "R4 opcode 5 left");
    send(64'h1234_5678_9ABC_DEF0, 64'hFEED_FACE_0BAD_F00D, 4'h4, 20, "R4 opcode 4 right");
    idle(3);
    send(64'h0, 64'h0, 4'h5, 100, "R1 imm_top w64");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'h5, 36, "R1 imm 36 w32");
    idle(2);
    for (int i = 0; i < 200; i++) begin
      logic [63:0] s, d;
      logic [3:0]  op;
      int imm;
      s   = {$urandom, $urandom};
      d   = {$urandom, $urandom};
      op  = ($urandom % 8 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'h5 : 4'h4);
      imm = int'($urandom % 128);
      send(s, d, op, imm, "R1 R2 R3 mixed");
      if (i % 7 == 0) idle(1);
    end
    idle(4);
    check(sb.size() == 0, "R8 all results returned", 64'(sb.size()), 64'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule